// File: doc/BRIEF.md
# Power-up strap capture and configuration decoder

This block reads the configuration straps of a multi-output clock generator exactly once, while power-on reset is being released, and turns them into a frozen configuration. Three straps are plain two-level inputs; a floating one reads as 1 because of a pull-up in the pad. The other three are three-level inputs. The pad digitises each of them into two comparator bits: one says the pin is above the high threshold, the other says it is below the low threshold. From these the block recognises low, high and a floating mid level. The mid level is a setting of its own.

A synchronised reset release starts a settle counter. When the count ends, two complementary reset phases swap state: the hold phase falls from 1 to 0 and the run phase rises from 0 to 1. On that swap the strap register closes and never opens again until the next power-on reset. Four of the strap pins are shared with 50 MHz clock outputs. Their driver enables may only come on after the register has closed. The frozen straps are decoded into the following settings:
- a memory-clock frequency code,
- a spread-spectrum setting,
- the enable and frequency select of the 25/100 MHz output,
- the enables and frequency select of the two 25/125 MHz outputs,
- an illegal-strap flag.

A valid flag follows the capture by one clock.

Top module: `clkgen_strap_ctrl`

## Requirements
- R1: While `por_n` is low, `cfg_valid`, `shared_pin_oe`, `grp100_oe` and `grp125_oe` are all 0. With the default of 8 settle cycles, the straps are captured on the 10th rising clock edge after `por_n` rises. That is two synchroniser stages plus SETTLE_CYCLES. `cfg_valid` rises on the 11th edge and stays high.
- R2: After capture, no change on any strap input alters any configuration output or `strap_err`.
- R3: `strap_in[0]` is the 50 MHz enable strap. When it is captured as 1, all four `shared_pin_oe` bits go to 1 on the capture edge. When it is captured as 0, they stay 0.
- R4: A three-level strap with comparator bits (`tri_above_hi`, `tri_below_lo`) decodes as (1,0) to level 1, (0,1) to level 0 and (0,0) to M. Strap index 0 is the 100 MHz group select, index 1 the 125 MHz group select and index 2 the spread select.
- R5: When both comparator bits of any three-level strap are set, `strap_err` is 1 and that strap is treated as M. Otherwise `strap_err` is 0.
- R6: `ss_mode` is 2'b10 (±0.75% center) for a spread strap of 0, 2'b00 (off) for M and 2'b01 (±0.5% center) for 1.
- R7: `mem_freq_code` equals {`strap_in[2]`, `strap_in[1]`} as captured. Code 00 means 100 MHz, 01 means 75 MHz, 10 means 83.3 MHz and 11 means 66.6 MHz.
- R8: The 100 MHz group strap sets `grp100_oe`/`grp100_sel` as follows: level 0 gives 1/0 (25 MHz), level 1 gives 1/1 (100 MHz), and M gives 0/0 (tri-stated).
- R9: The 125 MHz group strap sets `grp125_oe`/`grp125_sel` as follows: level 0 gives 2'b11/0 (25 MHz), M gives 2'b11/1 (125 MHz), and level 1 gives 2'b00/0 (both tri-stated).
- R10: Pulling `por_n` low again clears `cfg_valid` and all output enables. The next release captures the strap values present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| strap_in | input | 3 | Two-level straps: [0] 50 MHz enable, [1] frequency select low bit, [2] frequency select high bit |
| tri_above_hi | input | 3 | Above-high comparator bit for each three-level strap |
| tri_below_lo | input | 3 | Below-low comparator bit for each three-level strap |
| shared_pin_oe | output | 4 | Driver enables of the shared 50 MHz pins |
| mem_freq_code | output | 2 | Memory-clock frequency code |
| ss_mode | output | 2 | Spread-spectrum setting |
| grp100_oe | output | 1 | Enable of the 25/100 MHz output |
| grp100_sel | output | 1 | 1 selects 100 MHz, 0 selects 25 MHz |
| grp125_oe | output | 2 | Enables of the two 25/125 MHz outputs |
| grp125_sel | output | 1 | 1 selects 125 MHz, 0 selects 25 MHz |
| strap_err | output | 1 | A three-level strap had both comparator bits set |
| cfg_valid | output | 1 | Configuration is frozen and usable |

## Verification
The bench counts edges from reset release to the first driver enable and to `cfg_valid`. A design that captures early, while the pins are still settling, fails this count, and so does one that enables the shared drivers before the register closes. After each capture it inverts every strap input and compares all outputs again, so a transparent or re-arming latch shows up as a changed output. The strap patterns cover every level of each three-level strap, both illegal comparator pairs and all four frequency codes. A swapped mid/high decode therefore turns up as a wrong spread or group setting. Repeated power cycles catch a `cfg_valid` that is never cleared, and they also catch a value kept from the previous capture.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MID = 2'd1,
    LVL_HI  = 2'd2
  } tri_lvl_e;

  typedef enum logic [1:0] {
    SPREAD_OFF = 2'b00,
    SPREAD_050 = 2'b01,
    SPREAD_075 = 2'b10
  } spread_e;

  localparam int NUM_TWO_LVL = 3;
  localparam int NUM_TRI_LVL = 3;

  localparam int TWO_OE50  = 0;
  localparam int TWO_FSEL0 = 1;
  localparam int TWO_FSEL1 = 2;

  localparam int TRI_GRP100 = 0;
  localparam int TRI_GRP125 = 1;
  localparam int TRI_SPREAD = 2;

endpackage

// File: rtl/strap_rst_seq.sv
module strap_rst_seq #(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_sync,
  output logic capture,
  output logic ph_hold,
  output logic ph_run
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;
  logic                   hold_q, hold_d;
  logic                   run_q, run_d;

  // reset synchroniser: asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[SYNC_STAGES-1];

  // settle counter runs only while the strap register is still open
  assign cnt_en  = !run_q;
  assign capture = cnt_en && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    run_d  = run_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (capture) begin
      hold_d = 1'b0;
      run_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      hold_q <= hold_d;
      run_q  <= run_d;
    end
  end

  assign ph_hold = hold_q;
  assign ph_run  = run_q;

  // R1: the two reset phases are always complementary
  assert_phase_compl_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ph_hold != ph_run);

  // R2: capture fires a single time per power-up
  assert_capture_once_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    capture |=> (!capture && ph_run));

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         closed,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (capture) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= '0;
    else if (capture) q_r <= q_d;
  end

  assign q = q_r;

  // R2: once closed, the captured straps never move
  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    closed |=> $stable(q));

endmodule

// File: rtl/strap_tri_decode.sv
module strap_tri_decode
  import strap_pkg::*;
(
  input  logic     above_hi,
  input  logic     below_lo,
  output tri_lvl_e lvl,
  output logic     illegal
);
  always_comb begin
    illegal = above_hi && below_lo;
    unique case ({above_hi, below_lo})
      2'b10:   lvl = LVL_HI;
      2'b01:   lvl = LVL_LO;
      default: lvl = LVL_MID;
    endcase
  end
endmodule

// File: rtl/clkgen_strap_ctrl.sv
module clkgen_strap_ctrl
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int NUM_SHARED    = 4,
  parameter int NUM_GRP125    = 2
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic [NUM_TWO_LVL-1:0] strap_in,
  input  logic [NUM_TRI_LVL-1:0] tri_above_hi,
  input  logic [NUM_TRI_LVL-1:0] tri_below_lo,
  output logic [NUM_SHARED-1:0]  shared_pin_oe,
  output logic [1:0]             mem_freq_code,
  output logic [1:0]             ss_mode,
  output logic                   grp100_oe,
  output logic                   grp100_sel,
  output logic [NUM_GRP125-1:0]  grp125_oe,
  output logic                   grp125_sel,
  output logic                   strap_err,
  output logic                   cfg_valid
);
  localparam int LW = NUM_TWO_LVL + 2 * NUM_TRI_LVL;

  logic rst_n_sync, capture, ph_hold, ph_run;
  logic [LW-1:0] raw_straps, held;
  logic [NUM_TWO_LVL-1:0] two_q;
  logic [NUM_TRI_LVL-1:0] hi_q, lo_q, bad;
  tri_lvl_e lvl [NUM_TRI_LVL];
  spread_e  spread;
  logic     a_oe, a_sel, b_oe, b_sel;
  logic     valid_q, valid_d;

  strap_rst_seq #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n_sync(rst_n_sync),
    .capture   (capture),
    .ph_hold   (ph_hold),
    .ph_run    (ph_run)
  );

  assign raw_straps = {tri_below_lo, tri_above_hi, strap_in};

  strap_latch #(.W(LW)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .capture(capture),
    .closed (ph_run),
    .d      (raw_straps),
    .q      (held)
  );

  assign two_q = held[NUM_TWO_LVL-1:0];
  assign hi_q  = held[NUM_TWO_LVL +: NUM_TRI_LVL];
  assign lo_q  = held[NUM_TWO_LVL+NUM_TRI_LVL +: NUM_TRI_LVL];

  for (genvar i = 0; i < NUM_TRI_LVL; i++) begin : g_tri
    strap_tri_decode u_dec (
      .above_hi(hi_q[i]),
      .below_lo(lo_q[i]),
      .lvl     (lvl[i]),
      .illegal (bad[i])
    );
  end

  // option decode of the frozen straps
  always_comb begin
    unique case (lvl[TRI_SPREAD])
      LVL_LO:  spread = SPREAD_075;
      LVL_HI:  spread = SPREAD_050;
      default: spread = SPREAD_OFF;
    endcase
    unique case (lvl[TRI_GRP100])
      LVL_LO:  begin a_oe = 1'b1; a_sel = 1'b0; end
      LVL_HI:  begin a_oe = 1'b1; a_sel = 1'b1; end
      default: begin a_oe = 1'b0; a_sel = 1'b0; end
    endcase
    unique case (lvl[TRI_GRP125])
      LVL_LO:  begin b_oe = 1'b1; b_sel = 1'b0; end
      LVL_HI:  begin b_oe = 1'b0; b_sel = 1'b0; end
      default: begin b_oe = 1'b1; b_sel = 1'b1; end
    endcase
  end

  assign ss_mode       = spread;
  assign mem_freq_code = {two_q[TWO_FSEL1], two_q[TWO_FSEL0]};
  assign grp100_sel    = a_sel;
  assign grp125_sel    = b_sel;
  assign grp100_oe     = ph_run && a_oe;
  assign strap_err     = |bad;

  // shared pins turn to outputs only after the register closes
  for (genvar p = 0; p < NUM_SHARED; p++) begin : g_shared
    assign shared_pin_oe[p] = ph_run && two_q[TWO_OE50];
  end

  for (genvar g = 0; g < NUM_GRP125; g++) begin : g_grp125
    assign grp125_oe[g] = ph_run && b_oe;
  end

  assign valid_d = ph_run;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  assign cfg_valid = valid_q;

  // R1: valid only rises after the register has closed
  assert_valid_late_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(cfg_valid) |-> $past(ph_run));

  // R3: no shared driver is on while the hold phase is active
  assert_no_early_drive_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (|shared_pin_oe) |-> !ph_hold);

  // R2: the error flag cannot move once the configuration is valid
  assert_err_stable_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cfg_valid |=> $stable(strap_err));

  // R6: a mid spread strap never yields an active spread setting
  assert_spread_mid_off_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg_valid && lvl[TRI_SPREAD] == LVL_MID) |-> ss_mode == SPREAD_OFF);

  // R9: selecting 125 MHz implies both group outputs are driven
  assert_grp125_on_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg_valid && grp125_sel) |-> (&grp125_oe));

endmodule

// File: tb/clkgen_strap_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_strap_ctrl_test;
  localparam int SETTLE = 8;

  typedef struct packed {
    logic [3:0] pin_oe;
    logic [1:0] mem;
    logic [1:0] ss;
    logic       oe100;
    logic       sel100;
    logic [1:0] oe125;
    logic       sel125;
    logic       err;
  } cfg_t;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [2:0] strap_in = 3'b111;
  logic [2:0] tri_above_hi = 3'b000;
  logic [2:0] tri_below_lo = 3'b000;
  logic [3:0] shared_pin_oe;
  logic [1:0] mem_freq_code, ss_mode, grp125_oe;
  logic       grp100_oe, grp100_sel, grp125_sel, strap_err, cfg_valid;

  int compared = 0;
  int mismatched = 0;
  cfg_t  exp_q[$];
  string tag_q[$];
  bit    seen = 1'b0;

  always #5 clk = ~clk;

  clkgen_strap_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .por_n(por_n), .strap_in(strap_in),
    .tri_above_hi(tri_above_hi), .tri_below_lo(tri_below_lo),
    .shared_pin_oe(shared_pin_oe), .mem_freq_code(mem_freq_code),
    .ss_mode(ss_mode), .grp100_oe(grp100_oe), .grp100_sel(grp100_sel),
    .grp125_oe(grp125_oe), .grp125_sel(grp125_sel),
    .strap_err(strap_err), .cfg_valid(cfg_valid)
  );

  function automatic cfg_t actual();
    return '{shared_pin_oe, mem_freq_code, ss_mode, grp100_oe, grp100_sel,
             grp125_oe, grp125_sel, strap_err};
  endfunction

  // 0 = low, 1 = mid, 2 = high; both bits set counts as mid
  function automatic int level(logic h, logic l);
    if (h && !l) return 2;
    if (l && !h) return 0;
    return 1;
  endfunction

  function automatic cfg_t model(logic [2:0] s, logic [2:0] h, logic [2:0] l);
    cfg_t c;
    int la, lb, ls;
    la = level(h[0], l[0]);
    lb = level(h[1], l[1]);
    ls = level(h[2], l[2]);
    c.pin_oe = s[0] ? 4'hF : 4'h0;
    c.mem    = {s[2], s[1]};
    c.ss     = (ls == 0) ? 2'b10 : (ls == 2) ? 2'b01 : 2'b00;
    c.oe100  = (la != 1);
    c.sel100 = (la == 2);
    c.oe125  = (lb == 2) ? 2'b00 : 2'b11;
    c.sel125 = (lb == 1);
    c.err    = |(h & l);
    return c;
  endfunction

  task automatic check(string what, logic ok, string act, string expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %s expected %s", what, act, expv);
    end
  endtask

  // monitor: pops the expected configuration when cfg_valid first rises
  always @(negedge clk) begin
    if (!por_n) seen = 1'b0;
    else if (cfg_valid && !seen) begin
      seen = 1'b1;
      if (exp_q.size() == 0) begin
        check("R1 unexpected valid", 1'b0, "valid", "no item");
      end else begin
        cfg_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " R3 R4 R5 R6 R7 R8 R9 decode"}, actual() == e,
              $sformatf("%h", actual()), $sformatf("%h", e));
      end
    end
  end

  task automatic power_cycle(string tag, logic [2:0] s, logic [2:0] h, logic [2:0] l);
    cfg_t e;
    int first_oe, first_valid;
    e = model(s, h, l);
    @(negedge clk);
    por_n = 1'b0;
    strap_in = s;
    tri_above_hi = h;
    tri_below_lo = l;
    repeat (3) @(posedge clk);
    #1;
    check({tag, " R1 R10 reset state"},
          cfg_valid == 1'b0 && shared_pin_oe == 4'h0 && grp100_oe == 1'b0 && grp125_oe == 2'b00,
          $sformatf("v%b oe%h a%b b%b", cfg_valid, shared_pin_oe, grp100_oe, grp125_oe),
          "v0 oe0 a0 b0");
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    por_n = 1'b1;
    first_oe = 0;
    first_valid = 0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      #1;
      if (shared_pin_oe != 4'h0 && first_oe == 0) first_oe = i;
      if (cfg_valid && first_valid == 0) first_valid = i;
    end
    check({tag, " R1 valid edge"}, first_valid == SETTLE + 3,
          $sformatf("%0d", first_valid), $sformatf("%0d", SETTLE + 3));
    if (s[0])
      check({tag, " R3 driver enable edge"}, first_oe == SETTLE + 2,
            $sformatf("%0d", first_oe), $sformatf("%0d", SETTLE + 2));
    else
      check({tag, " R3 drivers held off"}, first_oe == 0,
            $sformatf("%0d", first_oe), "0");
    // R2: disturb every strap pin after capture
    @(negedge clk);
    strap_in = ~s;
    tri_above_hi = ~h;
    tri_below_lo = ~l;
    repeat (5) @(negedge clk);
    check({tag, " R2 frozen"}, actual() == e && cfg_valid,
          $sformatf("%h v%b", actual(), cfg_valid), $sformatf("%h v1", e));
  endtask

  initial begin
    #2_000_000;
    check("watchdog", 1'b0, "timeout", "finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // all pins floating: mid tri straps, pull-ups on two-level straps
    power_cycle("float",  3'b111, 3'b000, 3'b000);
    // all tri low, code 00 (100 MHz)
    power_cycle("lows",   3'b001, 3'b000, 3'b111);
    // all tri high, code 01 (75 MHz)
    power_cycle("highs",  3'b011, 3'b111, 3'b000);
    // 50 MHz drivers off, code 10 (83.3), illegal 100 group strap
    power_cycle("bad100", 3'b100, 3'b001, 3'b001);
    // illegal spread strap, mixed groups, code 11
    power_cycle("badss",  3'b111, 3'b101, 3'b110);
    // mixed: 100 high, 125 mid, spread low, code 00, drivers off
    power_cycle("mix",    3'b000, 3'b001, 3'b100);
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0)
      check("R1 pending items", 1'b0, $sformatf("%0d", exp_q.size()), "0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule